// File: doc/BRIEF.md
# Protection Tuple Inserter

This block fills in protection information in the metadata area that accompanies each logical block of a write. After a `start` pulse it takes one byte per cycle: first the data bytes of a block, then that block's metadata bytes. While the data passes through it runs a guard CRC over the bytes. It then re-emits the metadata area one byte per cycle with the protection tuple written over the tuple window. The tuple holds the guard, the application tag and the reference tag. The data bytes themselves are not re-emitted. Two tuple formats are supported: a 16-bit guard in an 8-byte tuple, and a 64-bit guard in a 16-byte tuple. The window sits either at the head or at the tail of the metadata area.

A zero-fill mode serves write-zeroes commands. In that mode the block reads nothing from its input. It produces every metadata area itself, with a fixed guard value.

The configuration is captured on `start`: format, placement, protection type, tags and block count. The reference tag advances from block to block according to the protection type.

Top module: `pi_tuple_gen`

## Requirements
- R1: In the 16-bit format the tuple is 8 bytes, all big-endian: guard[15:8], guard[7:0], app[15:8], app[7:0], then the low 32 bits of the reference tag with the most significant byte first.
- R2: In the 64-bit format the tuple is 16 bytes: the 64-bit guard with the most significant byte first, then app[15:8] and app[7:0], then the 48-bit reference tag as six bytes with the most significant byte first.
- R3: With `cfg_head`=1 the tuple occupies metadata offsets 0 to size-1. With `cfg_head`=0 it starts at offset MD_BYTES minus the tuple size.
- R4: With head placement the guard covers the block's data bytes only. With tail placement it covers the data bytes followed by every metadata byte that precedes the tuple.
- R5: The 16-bit guard is a CRC with polynomial 16'h8BB7. It shifts in each byte most significant bit first, starts from 0 and has no final XOR.
- R6: The 64-bit guard is a reflected CRC with the bit-reversed polynomial 64'h9A6C9269032B2F6D. It starts from all ones and is inverted at the end.
- R7: For `cfg_ptype` 1 or 2 the reference tag rises by one after each block. It wraps modulo 2^32 in the 16-bit format and modulo 2^48 in the 64-bit format. For `cfg_ptype`=3 every block carries the initial value.
- R8: Metadata bytes outside the tuple window are emitted unchanged. Data bytes produce no output.
- R9: With `cfg_zero`=1 no input is consumed. Each block yields MD_BYTES output bytes on consecutive cycles, starting two cycles after the `start` edge. Bytes outside the tuple are 0. The guard is 0 in the 16-bit format and 64'h6482D367EB22B64E in the 64-bit format.
- R10: An output byte appears one cycle after the accepted metadata byte it replaces. `done` is a one-cycle pulse in the cycle after the final output byte. `busy` is high from the cycle after `start` until the last byte is emitted.
- R11: `start` is ignored while busy, and `in_valid` is ignored while idle.
- R12: `cfg_blk_last` holds the block count minus one, so 0 means a single block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a transfer and captures the configuration |
| cfg_fmt64 | input | 1 | 1 selects the 64-bit guard format, 0 the 16-bit format |
| cfg_head | input | 1 | 1 places the tuple at the head of the metadata area |
| cfg_zero | input | 1 | Zero-fill generation mode |
| cfg_ptype | input | 2 | Protection type code (1, 2 or 3) |
| cfg_app | input | 16 | Application tag |
| cfg_ref | input | 48 | Initial reference tag |
| cfg_blk_last | input | NBLK_W | Number of blocks minus one |
| in_valid | input | 1 | Input byte strobe |
| in_byte | input | 8 | Data or metadata byte |
| busy | output | 1 | Transfer in progress |
| out_valid | output | 1 | Output metadata byte strobe |
| out_byte | output | 8 | Output metadata byte |
| done | output | 1 | Pulse after the final output byte |

## Verification
The stimulus table mixes both formats, both placements, all three protection types and zero-fill mode, over one to four blocks. Every emitted byte is compared against a reference model in the bench. A wrong placement, a wrong byte order or a wrong CRC span therefore shows up as a byte mismatch. Reference tags that start next to the 32-bit and 48-bit boundaries separate the two wrap widths. Type-3 vectors separate holding the tag from advancing it. Some vectors leave gaps in `in_valid`, and some pulse `start` again mid-run with a conflicting configuration. Idle input bytes are sent before the first run, and output and `done` timing are checked to the cycle.

// File: rtl/pi_gen_pkg.sv
package pi_gen_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_META = 2'd2,
        ST_ZGEN = 2'd3
    } pi_state_e;

    localparam logic [15:0] CRC16_POLY      = 16'h8BB7;
    localparam logic [63:0] CRC64_POLY_REFL = 64'h9A6C9269032B2F6D;
    localparam logic [63:0] ZERO_GUARD64    = 64'h6482D367EB22B64E;

    // Byte idx of the big-endian tuple; the short format is left-aligned.
    function automatic logic [7:0] tuple_byte(input logic        fmt64,
                                              input logic [63:0] guard,
                                              input logic [15:0] app,
                                              input logic [47:0] ref_tag,
                                              input logic [3:0]  idx);
        logic [127:0] t;
        if (fmt64) t = {guard, app, ref_tag};
        else       t = {guard[15:0], app, ref_tag[31:0], 64'h0};
        return t[8*(15 - int'(idx)) +: 8];
    endfunction

endpackage

// File: rtl/pi_crc16_unit.sv
module pi_crc16_unit
    import pi_gen_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc
);
    logic [15:0] crc_d, crc_q;

    always_comb begin
        logic [15:0] c;
        c = crc_q;
        for (int i = 0; i < 8; i++) begin
            if (c[15] ^ din[7-i]) c = {c[14:0], 1'b0} ^ CRC16_POLY;
            else                  c = {c[14:0], 1'b0};
        end
        if (clr)     crc_d = '0;
        else if (en) crc_d = c;
        else         crc_d = crc_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= '0;
        else        crc_q <= crc_d;
    end

    assign crc = crc_q;

    AST_CRC16_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (crc == 16'h0)); // R5
endmodule

// File: rtl/pi_crc64_unit.sv
module pi_crc64_unit
    import pi_gen_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [63:0] crc
);
    logic [63:0] crc_d, crc_q;

    always_comb begin
        logic [63:0] c;
        c = crc_q ^ {56'h0, din};
        for (int i = 0; i < 8; i++) begin
            if (c[0]) c = (c >> 1) ^ CRC64_POLY_REFL;
            else      c = c >> 1;
        end
        if (clr)     crc_d = '1;
        else if (en) crc_d = c;
        else         crc_d = crc_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= '1;
        else        crc_q <= crc_d;
    end

    assign crc = ~crc_q;

    AST_CRC64_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (crc == 64'h0)); // R6
endmodule

// File: rtl/pi_tuple_mux.sv
module pi_tuple_mux
    import pi_gen_pkg::*;
#(
    parameter int MD_BYTES = 24,
    parameter int POS_W    = 5
) (
    input  logic [POS_W-1:0] pos,
    input  logic             fmt64,
    input  logic             head,
    input  logic             zero_mode,
    input  logic [15:0]      crc16,
    input  logic [63:0]      crc64,
    input  logic [15:0]      app,
    input  logic [47:0]      ref_tag,
    output logic             in_tuple,
    output logic             before_tuple,
    output logic [7:0]       tbyte
);
    localparam int SHORT_SIZE = 8;
    localparam int LONG_SIZE  = 16;

    int          tsize, off, p;
    logic [63:0] guard;

    always_comb begin
        tsize        = fmt64 ? LONG_SIZE : SHORT_SIZE;
        off          = head ? 0 : (MD_BYTES - tsize);
        p            = int'(pos);
        in_tuple     = (p >= off) && (p < off + tsize);
        before_tuple = (p < off);
        if (zero_mode) guard = fmt64 ? ZERO_GUARD64 : 64'h0;
        else           guard = fmt64 ? crc64 : {48'h0, crc16};
        tbyte        = tuple_byte(fmt64, guard, app, ref_tag, 4'(p - off));
    end
endmodule

// File: rtl/pi_tuple_gen.sv
module pi_tuple_gen
    import pi_gen_pkg::*;
#(
    parameter int BLK_BYTES = 16,
    parameter int MD_BYTES  = 24,
    parameter int NBLK_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cfg_fmt64,
    input  logic              cfg_head,
    input  logic              cfg_zero,
    input  logic [1:0]        cfg_ptype,
    input  logic [15:0]       cfg_app,
    input  logic [47:0]       cfg_ref,
    input  logic [NBLK_W-1:0] cfg_blk_last,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    output logic              busy,
    output logic              out_valid,
    output logic [7:0]        out_byte,
    output logic              done
);
    localparam int MAX_BYTES = (BLK_BYTES > MD_BYTES) ? BLK_BYTES : MD_BYTES;
    localparam int POS_W     = $clog2(MAX_BYTES + 1);
    localparam logic [POS_W-1:0] DATA_END = POS_W'(BLK_BYTES - 1);
    localparam logic [POS_W-1:0] META_END = POS_W'(MD_BYTES - 1);

    typedef struct packed {
        pi_state_e         st;
        logic [POS_W-1:0]  pos;
        logic [NBLK_W-1:0] blk;
        logic [NBLK_W-1:0] blk_last;
        logic [47:0]       ref_tag;
        logic [15:0]       app;
        logic [1:0]        ptype;
        logic              fmt64;
        logic              head;
        logic              zero;
        logic              ov;
        logic [7:0]        ob;
        logic              olast;
        logic              done;
    } regs_t;

    regs_t       r_d, r_q;
    logic        crc_clr, crc_en, step_md;
    logic        in_tuple, before_tuple;
    logic [7:0]  tbyte;
    logic [15:0] crc16;
    logic [63:0] crc64;

    pi_crc16_unit u_crc16 (
        .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(crc_en),
        .din(in_byte), .crc(crc16)
    );

    pi_crc64_unit u_crc64 (
        .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(crc_en),
        .din(in_byte), .crc(crc64)
    );

    pi_tuple_mux #(.MD_BYTES(MD_BYTES), .POS_W(POS_W)) u_mux (
        .pos(r_q.pos), .fmt64(r_q.fmt64), .head(r_q.head),
        .zero_mode(r_q.zero), .crc16(crc16), .crc64(crc64),
        .app(r_q.app), .ref_tag(r_q.ref_tag),
        .in_tuple(in_tuple), .before_tuple(before_tuple), .tbyte(tbyte)
    );

    always_comb begin
        r_d       = r_q;
        r_d.ov    = 1'b0;
        r_d.olast = 1'b0;
        r_d.done  = r_q.olast;
        crc_clr   = 1'b0;
        crc_en    = 1'b0;
        step_md   = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.fmt64    = cfg_fmt64;
                    r_d.head     = cfg_head;
                    r_d.zero     = cfg_zero;
                    r_d.ptype    = cfg_ptype;
                    r_d.app      = cfg_app;
                    r_d.ref_tag  = cfg_ref;
                    r_d.blk_last = cfg_blk_last;
                    r_d.pos      = '0;
                    r_d.blk      = '0;
                    crc_clr      = 1'b1;
                    r_d.st       = cfg_zero ? ST_ZGEN : ST_DATA;
                end
            end
            ST_DATA: begin
                if (in_valid) begin
                    crc_en = 1'b1;
                    if (r_q.pos == DATA_END) begin
                        r_d.pos = '0;
                        r_d.st  = ST_META;
                    end else begin
                        r_d.pos = r_q.pos + 1'b1;
                    end
                end
            end
            ST_META: begin
                if (in_valid) begin
                    crc_en  = before_tuple;
                    r_d.ov  = 1'b1;
                    r_d.ob  = in_tuple ? tbyte : in_byte;
                    step_md = 1'b1;
                end
            end
            default: begin
                r_d.ov  = 1'b1;
                r_d.ob  = in_tuple ? tbyte : 8'h00;
                step_md = 1'b1;
            end
        endcase

        if (step_md) begin
            if (r_q.pos == META_END) begin
                r_d.pos = '0;
                crc_clr = 1'b1;
                crc_en  = 1'b0;
                if (r_q.ptype != 2'd3) r_d.ref_tag = r_q.ref_tag + 48'd1;
                if (r_q.blk == r_q.blk_last) begin
                    r_d.st    = ST_IDLE;
                    r_d.olast = 1'b1;
                end else begin
                    r_d.blk = r_q.blk + 1'b1;
                    r_d.st  = r_q.zero ? ST_ZGEN : ST_DATA;
                end
            end else begin
                r_d.pos = r_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy      = (r_q.st != ST_IDLE);
    assign out_valid = r_q.ov;
    assign out_byte  = r_q.ob;
    assign done      = r_q.done;

    AST_REF_HELD_T3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && r_q.ptype == 2'd3) |=> (r_q.ref_tag == $past(r_q.ref_tag))); // R7
    AST_CFG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(r_q.app) && $stable(r_q.fmt64) && $stable(r_q.blk_last))); // R11
    AST_OUT_FROM_META: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(r_q.st) == ST_META || $past(r_q.st) == ST_ZGEN)); // R8
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid); // R10
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> !busy); // R11
endmodule

// File: tb/test_pi_tuple_gen.sv
`timescale 1ns/1ps
module test_pi_tuple_gen;
    localparam int BLK = 16;
    localparam int MD  = 24;
    localparam int MAXB = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cfg_fmt64 = 1'b0, cfg_head = 1'b0, cfg_zero = 1'b0;
    logic [1:0]  cfg_ptype = 2'd1;
    logic [15:0] cfg_app = '0;
    logic [47:0] cfg_ref = '0;
    logic [7:0]  cfg_blk_last = '0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        busy, out_valid, done;
    logic [7:0]  out_byte;

    pi_tuple_gen #(.BLK_BYTES(BLK), .MD_BYTES(MD), .NBLK_W(8)) i_pi_tuple_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_fmt64(cfg_fmt64),
        .cfg_head(cfg_head), .cfg_zero(cfg_zero), .cfg_ptype(cfg_ptype),
        .cfg_app(cfg_app), .cfg_ref(cfg_ref), .cfg_blk_last(cfg_blk_last),
        .in_valid(in_valid), .in_byte(in_byte), .busy(busy),
        .out_valid(out_valid), .out_byte(out_byte), .done(done)
    );

    always #2 clk = ~clk;

    typedef struct packed {
        logic        fmt64;
        logic        head;
        logic        zero;
        logic        gap;
        logic        poke;
        logic [1:0]  ptype;
        logic [7:0]  nlast;
        logic [15:0] app;
        logic [47:0] reft;
        logic [7:0]  seed;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 8'd2, 16'h1234, 48'h0000_0000_0010, 8'd11},
        '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'd2, 8'd1, 16'hABCD, 48'h0000_FFFF_FFFF, 8'd5},
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 8'd2, 16'h5A5A, 48'h0012_3456_789A, 8'd77},
        '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 2'd3, 8'd2, 16'h00FF, 48'h0000_0000_00AA, 8'd201},
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd3, 8'd1, 16'h0F0F, 48'h0000_1234_5678, 8'd0},
        '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd2, 8'd2, 16'hC3C3, 48'hFFFF_FFFF_FFFF, 8'd0},
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2'd1, 8'd0, 16'h7777, 48'h0000_0000_0100, 8'd3},
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd3, 8'd3, 16'hFFFF, 48'h0000_8000_0001, 8'd250}
    };

    int checks = 0;
    int fails  = 0;
    int pcyc   = 0;
    int n_got  = 0;
    int n_done = 0;
    int last_out_cyc = 0;
    int done_cyc = 0;
    logic [7:0] got   [MAXB*MD];
    logic [7:0] exp_b [MAXB*MD];

    always @(posedge clk) pcyc++;

    always @(negedge clk) begin
        if (out_valid) begin
            if (n_got < MAXB*MD) got[n_got] = out_byte;
            n_got++;
            last_out_cyc = pcyc;
        end
        if (done) begin
            n_done++;
            done_cyc = pcyc;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic string vec_tag(input int i);
        case (i)
            0: return "R1 R3 R4 R5 R7 R8";
            1: return "R1 R3 R5 R7 R8";
            2: return "R2 R3 R4 R6 R7 R8";
            3: return "R2 R3 R6 R7 R8";
            4: return "R1 R9";
            5: return "R2 R7 R9";
            6: return "R2 R6 R11 R12";
            default: return "R1 R4 R5 R7 R11";
        endcase
    endfunction

    function automatic logic [7:0] data_at(input logic [7:0] seed, input int b, input int k);
        return 8'(int'(seed) * 3 + k * 37 + b * 101 + 1);
    endfunction

    function automatic logic [7:0] md_at(input logic [7:0] seed, input int b, input int k);
        return 8'(int'(seed) ^ (k * 53 + b * 17 + 9));
    endfunction

    function automatic logic [15:0] m_crc16(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] x;
        x = c;
        for (int i = 7; i >= 0; i--) begin
            logic fb;
            fb = x[15] ^ d[i];
            x  = x << 1;
            if (fb) x = x ^ 16'h8BB7;
        end
        return x;
    endfunction

    function automatic logic [63:0] m_crc64(input logic [63:0] c, input logic [7:0] d);
        logic [63:0] x;
        x = c;
        for (int i = 0; i < 8; i++) begin
            logic fb;
            fb = x[0] ^ d[i];
            x  = x >> 1;
            if (fb) x = x ^ 64'h9A6C9269032B2F6D;
        end
        return x;
    endfunction

    task automatic build_expected(input vec_t v);
        int          tsize, off;
        logic [47:0] rt;
        logic [15:0] g16;
        logic [63:0] g64;
        logic [7:0]  tb [16];
        tsize = v.fmt64 ? 16 : 8;
        off   = v.head ? 0 : MD - tsize;
        rt    = v.reft;
        for (int b = 0; b <= int'(v.nlast); b++) begin
            g16 = 16'h0;
            g64 = 64'hFFFF_FFFF_FFFF_FFFF;
            if (!v.zero) begin
                for (int k = 0; k < BLK; k++) begin
                    g16 = m_crc16(g16, data_at(v.seed, b, k));
                    g64 = m_crc64(g64, data_at(v.seed, b, k));
                end
                for (int k = 0; k < off; k++) begin
                    g16 = m_crc16(g16, md_at(v.seed, b, k));
                    g64 = m_crc64(g64, md_at(v.seed, b, k));
                end
                g64 = ~g64;
            end else begin
                g16 = 16'h0;
                g64 = 64'h6482D367EB22B64E;
            end
            for (int j = 0; j < 16; j++) begin
                if (v.fmt64) begin
                    if (j < 8)       tb[j] = 8'(g64 >> (56 - 8*j));
                    else if (j < 10) tb[j] = 8'(v.app >> (8 - 8*(j-8)));
                    else             tb[j] = 8'(rt >> (8*(15 - j)));
                end else begin
                    if (j < 2)       tb[j] = 8'(g16 >> (8 - 8*j));
                    else if (j < 4)  tb[j] = 8'(v.app >> (8 - 8*(j-2)));
                    else if (j < 8)  tb[j] = 8'(rt[31:0] >> (8*(7 - j)));
                    else             tb[j] = 8'h00;
                end
            end
            for (int k = 0; k < MD; k++) begin
                if (k >= off && k < off + tsize) exp_b[b*MD + k] = tb[k - off];
                else exp_b[b*MD + k] = v.zero ? 8'h00 : md_at(v.seed, b, k);
            end
            if (v.ptype != 2'd3) rt = rt + 48'd1;
        end
    endtask

    task automatic run_vec(input int vi);
        vec_t  v;
        int    nb, start_cyc, last_drive, t;
        string tag;
        v   = VECS[vi];
        tag = vec_tag(vi);
        nb  = int'(v.nlast) + 1;
        build_expected(v);
        @(posedge clk);
        n_got  = 0;
        n_done = 0;
        @(negedge clk);
        cfg_fmt64 = v.fmt64; cfg_head = v.head; cfg_zero = v.zero;
        cfg_ptype = v.ptype; cfg_app = v.app; cfg_ref = v.reft;
        cfg_blk_last = v.nlast;
        start = 1'b1;
        start_cyc = pcyc;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R10 busy after start", 64'(busy), 64'd1);
        last_drive = 0;
        if (!v.zero) begin
            for (int b = 0; b < nb; b++) begin
                for (int k = 0; k < BLK + MD; k++) begin
                    if (v.gap && (k % 3 == 2)) begin
                        in_valid = 1'b0;
                        @(negedge clk);
                    end
                    in_valid = 1'b1;
                    in_byte  = (k < BLK) ? data_at(v.seed, b, k) : md_at(v.seed, b, k - BLK);
                    if (v.poke && b == 0 && k == 5) begin
                        start = 1'b1;
                        cfg_fmt64 = ~v.fmt64; cfg_head = ~v.head; cfg_zero = 1'b1;
                        cfg_app = ~v.app; cfg_ref = '0; cfg_blk_last = 8'd3;
                    end
                    last_drive = pcyc;
                    @(negedge clk);
                    start = 1'b0;
                end
            end
            in_valid = 1'b0;
        end
        t = 0;
        while (!done && t < 3000) begin
            @(negedge clk);
            t++;
        end
        repeat (3) @(negedge clk);
        @(posedge clk);
        #1;
        check(n_got == nb * MD, {tag, " R12 output byte count"}, 64'(n_got), 64'(nb * MD));
        for (int b = 0; b < nb && b < MAXB; b++) begin
            int bad;
            bad = -1;
            for (int k = MD - 1; k >= 0; k--)
                if (got[b*MD + k] !== exp_b[b*MD + k]) bad = k;
            if (bad < 0) check(1'b1, tag, 64'd0, 64'd0);
            else check(1'b0, {tag, $sformatf(" block %0d byte %0d", b, bad)},
                       64'(got[b*MD + bad]), 64'(exp_b[b*MD + bad]));
        end
        check(n_done == 1, "R10 single done pulse", 64'(n_done), 64'd1);
        if (v.zero) begin
            check(done_cyc == start_cyc + 2 + nb * MD, "R9 zero-fill timing",
                  64'(done_cyc), 64'(start_cyc + 2 + nb * MD));
        end else begin
            check(last_out_cyc == last_drive + 1, "R10 output latency",
                  64'(last_out_cyc), 64'(last_drive + 1));
            check(done_cyc == last_drive + 2, "R10 done timing",
                  64'(done_cyc), 64'(last_drive + 2));
        end
        check(busy == 1'b0, "R10 busy cleared", 64'(busy), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog expired: actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check(out_valid == 1'b0, "R10 reset out_valid", 64'(out_valid), 64'd0);
        check(done == 1'b0, "R10 reset done", 64'(done), 64'd0);
        check(busy == 1'b0, "R10 reset busy", 64'(busy), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: bytes offered while idle must produce nothing
        for (int i = 0; i < 12; i++) begin
            in_valid = 1'b1;
            in_byte  = 8'(i * 19 + 7);
            @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        @(posedge clk);
        #1;
        check(n_got == 0 && busy == 1'b0, "R11 idle input ignored", 64'(n_got), 64'd0);
        for (int vi = 0; vi < NV; vi++) run_vec(vi);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule